// File: doc/BRIEF.md
# Indirect Register Access Controller

This block is the CPU-facing register front end of a peripheral. A 2-bit address picks one of four byte-wide ports. Three are direct data ports, each tied to a fixed register. The fourth is a control port that reaches a 48-entry register file through a two-phase pointer protocol. In the select phase, a control write loads a register number. In the data phase, the next control access moves a byte to or from that register. A single phase flip-flop tracks where the protocol is. Every control write toggles it, and every control read clears it, so a dummy read puts the CPU back in step.

Register 00h carries a software reset bit in its bit 0. Writing that bit to 1 through the control port locks the block. While locked, the control port stays in the data phase and every control write lands in register 00h. All other registers read 00h, and data-port writes are dropped. A control write with bit 0 clear ends the lock. The registers are plain storage; whatever functions sit behind them are outside this block. Every access completes in one clock and is qualified by a chip select and separate read and write strobes.

Top module: `indirect_reg_ctrl`

## Requirements
- R1: After an asynchronous reset, the phase is select, the pointer is 00h, all 48 registers hold 00h, the block is unlocked and `rdata_o` reads 00h.
- R2: `addr_i` = 0, 1 and 2 reach registers 0Dh, 0Eh and 0Fh directly. A write through either a data port or the control port is visible through the other path.
- R3: A control write (`addr_i` = 3) in the select phase loads `wdata_i[5:0]` as the pointer, ignores bits 7:6, writes no register, and moves to the data phase.
- R4: A control write in the data phase stores `wdata_i` into the register at the pointer and returns to the select phase.
- R5: A control read returns the register at the pointer in either phase, leaves the pointer unchanged, and always leaves the phase at select when the block is unlocked.
- R6: A pointer of 30h to 3Fh selects nothing: data-phase writes are discarded and reads return 00h.
- R7: A data-phase control write with pointer 00h and `wdata_i[0]` = 1 stores the byte and locks the block. While locked, the phase stays at data, every control write goes to register 00h, and a control write with bit 0 = 0 stores the byte, unlocks, and returns to select.
- R8: While locked, registers 01h to 2Fh hold 00h, data-port writes are ignored, and control reads return register 00h without changing the phase.
- R9: `rdata_o` is 00h unless `cs_i` and `rd_i` are high and `wr_i` is low. With both strobes high the access is a write. Data-port accesses never change the phase or the pointer.
- R10: With `cs_i` low, no register, pointer or phase changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (takes priority over `rd_i`) |
| addr_i | input | 2 | Port select: 0/1/2 data ports, 3 control port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle, 00h otherwise |

## Verification
A wrong phase bit does not show up at once. It appears at the next control access, which then either loads the pointer where data was expected or stores a byte where a pointer was expected. The bench exposes this within one or two accesses by reading the control port after every write sequence. A wrong pointer or a wrong alias shows up as a wrong byte on the very read that follows. A lock that is entered or left at the wrong time shows up as nonzero data on a data port, or as a control write landing somewhere other than register 00h. The reference model is compared against `rdata_o` on every clock, so each of these faults is reported in the cycle of the first read that can see it.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int DATA_W     = 8;
  localparam int N_REGS     = 48;
  localparam int PTR_W      = 6;
  localparam int ALIAS_BASE = 13;

  typedef enum logic [1:0] {
    PORT_A   = 2'd0,
    PORT_B   = 2'd1,
    PORT_C   = 2'd2,
    PORT_CTL = 2'd3
  } port_e;

  typedef enum logic {
    PH_SEL  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/irc_access_fsm.sv
module irc_access_fsm #(
  parameter int PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic             ctl_rd_i,
  input  logic [PTR_W-1:0] sel_i,
  output logic             phase_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             lock_o,
  output logic             lock_set_o,
  output logic             reg_we_o,
  output logic [PTR_W-1:0] reg_addr_o
);
  import irc_pkg::*;

  phase_e           phase_q, phase_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             lock_q, lock_d;
  logic             lock_set, lock_clr;

  assign lock_set = ctl_wr_i && (phase_q == PH_DATA) && !lock_q
                    && (ptr_q == '0) && sel_i[0];
  assign lock_clr = ctl_wr_i && lock_q && !sel_i[0];

  always_comb begin
    phase_d = phase_q;
    ptr_d   = ptr_q;
    lock_d  = lock_q;
    if (ctl_wr_i) begin
      if (lock_q) begin
        // pinned in data phase until bit 0 cleared
        phase_d = sel_i[0] ? PH_DATA : PH_SEL;
        lock_d  = sel_i[0];
      end else if (phase_q == PH_SEL) begin
        ptr_d   = sel_i;
        phase_d = PH_DATA;
      end else if (lock_set) begin
        phase_d = PH_DATA;
        lock_d  = 1'b1;
      end else begin
        phase_d = PH_SEL;
      end
    end else if (ctl_rd_i && !lock_q) begin
      phase_d = PH_SEL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SEL;
      ptr_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
      lock_q  <= lock_d;
    end
  end

  assign phase_o    = (phase_q == PH_DATA);
  assign ptr_o      = ptr_q;
  assign lock_o     = lock_q;
  assign lock_set_o = lock_set;
  assign reg_we_o   = ctl_wr_i && ((phase_q == PH_DATA) || lock_q);
  assign reg_addr_o = lock_q ? '0 : ptr_q;

  logic unused_clr;
  assign unused_clr = lock_clr;
endmodule

// File: rtl/irc_regfile.sv
module irc_regfile #(
  parameter int N_REGS = 48,
  parameter int DW     = 8,
  parameter int AW     = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          clr_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] LIMIT = AW'(N_REGS);

  logic [DW-1:0] regs_q [N_REGS];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[i] <= '0;
      end else if (clr_i && (i != 0)) begin
        regs_q[i] <= '0;
      end else if (we_i && (waddr_i == IDX)) begin
        regs_q[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_REGS; k++) begin
      if (raddr_i == AW'(k)) rdata_o = regs_q[k];
    end
    if (raddr_i >= LIMIT) rdata_o = '0;
  end
endmodule

// File: rtl/indirect_reg_ctrl.sv
module indirect_reg_ctrl #(
  parameter int DATA_W     = irc_pkg::DATA_W,
  parameter int N_REGS     = irc_pkg::N_REGS,
  parameter int PTR_W      = irc_pkg::PTR_W,
  parameter int ALIAS_BASE = irc_pkg::ALIAS_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  import irc_pkg::*;

  localparam logic [PTR_W-1:0] ALIAS = PTR_W'(ALIAS_BASE);

  logic             is_ctl, ctl_wr, ctl_rd, rd_act, dp_we;
  logic             phase_q, lock_q, lock_set;
  logic [PTR_W-1:0] ptr_q, fsm_addr, dp_addr;
  logic             fsm_we, rf_we, rf_clr;
  logic [PTR_W-1:0] rf_waddr, rf_raddr;
  logic [DATA_W-1:0] rf_rdata;

  assign is_ctl = (port_e'(addr_i) == PORT_CTL);
  assign ctl_wr = cs_i && wr_i && is_ctl;
  assign ctl_rd = cs_i && rd_i && !wr_i && is_ctl;
  assign rd_act = cs_i && rd_i && !wr_i;
  assign dp_we  = cs_i && wr_i && !is_ctl && !lock_q;
  assign dp_addr = ALIAS + PTR_W'(addr_i);

  irc_access_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr),
    .ctl_rd_i   (ctl_rd),
    .sel_i      (wdata_i[PTR_W-1:0]),
    .phase_o    (phase_q),
    .ptr_o      (ptr_q),
    .lock_o     (lock_q),
    .lock_set_o (lock_set),
    .reg_we_o   (fsm_we),
    .reg_addr_o (fsm_addr)
  );

  assign rf_we    = fsm_we || dp_we;
  assign rf_waddr = is_ctl ? fsm_addr : dp_addr;
  assign rf_raddr = is_ctl ? fsm_addr : dp_addr;
  assign rf_clr   = lock_q || lock_set;

  irc_regfile #(.N_REGS(N_REGS), .DW(DATA_W), .AW(PTR_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (wdata_i),
    .clr_i   (rf_clr),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  assign rdata_o = rd_act ? rf_rdata : '0;
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int DATA_W = 8,
  parameter int N_REGS = 48,
  parameter int PTR_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              phase_q,
  input logic [PTR_W-1:0]  ptr_q,
  input logic              lock_q
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(N_REGS);

  logic c_wr, c_rd, entering;
  assign c_wr = cs_i && wr_i && (addr_i == 2'd3);
  assign c_rd = cs_i && rd_i && !wr_i && (addr_i == 2'd3);
  assign entering = c_wr && phase_q && !lock_q && (ptr_q == '0) && wdata_i[0];

  AST_SEL_LOADS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr && !phase_q && !lock_q |=> phase_q && (ptr_q == $past(wdata_i[PTR_W-1:0]))); // R3
  AST_DATA_WR_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr && phase_q && !lock_q && !entering |=> !phase_q); // R4
  AST_RD_CLEARS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd && !lock_q |=> !phase_q && $stable(ptr_q)); // R5
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rd && !lock_q && (ptr_q >= LIMIT) |-> rdata_o == '0); // R6
  AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entering |=> lock_q && phase_q); // R7
  AST_LOCK_PINS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> phase_q); // R7
  AST_LOCK_DP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && cs_i && rd_i && !wr_i && (addr_i != 2'd3) |-> rdata_o == '0); // R8
  AST_DP_NO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && (addr_i != 2'd3) |=> $stable(phase_q) && $stable(ptr_q)); // R9
  AST_NO_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(phase_q) && $stable(ptr_q) && $stable(lock_q)); // R10
endmodule

bind indirect_reg_ctrl irc_checker #(
  .DATA_W(DATA_W), .N_REGS(N_REGS), .PTR_W(PTR_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .phase_q (phase_q),
  .ptr_q   (ptr_q),
  .lock_q  (lock_q)
);

// File: tb/indirect_reg_ctrl_tb.sv
module indirect_reg_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_mem [48];
  bit m_phase = 0;
  bit m_lock = 0;
  int m_ptr = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  indirect_reg_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic int model_read(bit cs, bit rd, bit wr, int a);
    if (!(cs && rd && !wr)) return 0;
    if (a < 3) return m_mem[13 + a];
    if (m_lock) return m_mem[0];
    return (m_ptr < 48) ? m_mem[m_ptr] : 0;
  endfunction

  function automatic void model_step(bit cs, bit rd, bit wr, int a, int d);
    if (!cs) return;
    if (wr) begin
      if (a < 3) begin
        if (!m_lock) m_mem[13 + a] = d;
      end else if (m_lock) begin
        m_mem[0] = d;
        if ((d & 1) == 0) begin m_lock = 0; m_phase = 0; end
      end else if (!m_phase) begin
        m_ptr = d & 63;
        m_phase = 1;
      end else begin
        if (m_ptr < 48) m_mem[m_ptr] = d;
        if (m_ptr == 0 && (d & 1) == 1) begin
          m_lock = 1;
          for (int k = 1; k < 48; k++) m_mem[k] = 0;
        end else begin
          m_phase = 0;
        end
      end
    end else if (rd && a == 3 && !m_lock) begin
      m_phase = 0;
    end
  endfunction

  task automatic cyc(bit cs, bit rd, bit wr, int a, int d, string tag);
    int exp;
    @(negedge clk_i);
    cs_i = cs; rd_i = rd; wr_i = wr; addr_i = 2'(a); wdata_i = 8'(d);
    #1;
    exp = model_read(cs, rd, wr, a);
    checks++;
    if (int'(rdata_o) != exp) begin
      errors++;
      $display("FAIL %s: addr=%0d rdata=%02h expected=%02h", tag, a, rdata_o, exp);
    end
    @(posedge clk_i);
    model_step(cs, rd, wr, a, d);
  endtask

  task automatic wr_t(int a, int d, string tag); cyc(1, 0, 1, a, d, tag); endtask
  task automatic rd_t(int a, string tag);        cyc(1, 1, 0, a, 0, tag); endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 48; k++) m_mem[k] = 0;
    repeat (3) @(negedge clk_i);
    #1;
    checks++;
    if (rdata_o !== 8'h00) begin
      errors++;
      $display("FAIL R1: rdata=%02h expected=00 in reset", rdata_o);
    end
    rst_ni = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, 0, 0, "R1");
    rd_t(3, "R1");
    for (int a = 0; a < 3; a++) rd_t(a, "R1");
    rd_t(3, "R1");
    // R3 / R4 / R5 basic protocol
    wr_t(3, 8'h05, "R3"); wr_t(3, 8'hA5, "R4"); rd_t(3, "R5"); rd_t(3, "R5");
    wr_t(3, 8'hC7, "R3"); wr_t(3, 8'h3C, "R4"); rd_t(3, "R3");
    // R2 aliases
    wr_t(0, 8'h11, "R2"); wr_t(3, 8'h0D, "R2"); rd_t(3, "R2");
    wr_t(3, 8'h0F, "R2"); wr_t(3, 8'h77, "R2"); rd_t(2, "R2");
    wr_t(1, 8'h22, "R2"); wr_t(3, 8'h0E, "R2"); rd_t(3, "R2");
    // R5 dummy read resync
    wr_t(3, 8'h07, "R5"); rd_t(3, "R5"); wr_t(3, 8'h0A, "R5"); wr_t(3, 8'h5A, "R5"); rd_t(3, "R5");
    rd_t(3, "R5"); wr_t(3, 8'h0A, "R5"); rd_t(3, "R5");
    // R6 out-of-range pointer
    wr_t(3, 8'h30, "R6"); wr_t(3, 8'hFF, "R6"); rd_t(3, "R6");
    wr_t(3, 8'h3F, "R6"); rd_t(3, "R6"); wr_t(3, 8'h2F, "R6"); wr_t(3, 8'h99, "R6"); rd_t(3, "R6");
    // R10 no chip select
    cyc(0, 0, 1, 0, 8'hEE, "R10"); rd_t(0, "R10");
    cyc(0, 0, 1, 3, 8'h0D, "R10"); wr_t(3, 8'h0D, "R10"); rd_t(3, "R10");
    // R9 both strobes: write wins, data port leaves phase
    cyc(1, 1, 1, 3, 8'h05, "R9"); cyc(1, 1, 0, 0, 0, "R9"); cyc(1, 0, 1, 1, 8'h44, "R9");
    cyc(1, 1, 1, 3, 8'h66, "R9"); rd_t(3, "R9"); cyc(1, 1, 0, 2, 0, "R9");
    // R4 sweep of the whole file
    for (int r = 0; r < 48; r++) begin
      if (r != 0) begin
        wr_t(3, r, "R4"); wr_t(3, (r * 37 + 3) & 255, "R4");
      end
    end
    for (int r = 0; r < 48; r++) begin
      wr_t(3, r, "R4"); rd_t(3, "R4");
    end
    // R7 / R8 software reset lock
    wr_t(3, 8'h00, "R7"); wr_t(3, 8'h81, "R7");
    rd_t(0, "R8"); rd_t(1, "R8"); wr_t(2, 8'h55, "R8"); rd_t(2, "R8");
    rd_t(3, "R8"); rd_t(3, "R8");
    wr_t(3, 8'h0D, "R7"); rd_t(3, "R7");
    wr_t(3, 8'h03, "R7"); rd_t(3, "R7");
    wr_t(3, 8'h02, "R7"); rd_t(3, "R7");
    wr_t(3, 8'h0D, "R8"); rd_t(3, "R8");
    wr_t(3, 8'h20, "R8"); rd_t(3, "R8");
    // normal operation resumes
    wr_t(0, 8'h9C, "R2"); rd_t(0, "R2"); wr_t(3, 8'h0D, "R2"); rd_t(3, "R2");
    wr_t(3, 8'h10, "R4"); wr_t(3, 8'hB4, "R4"); wr_t(3, 8'h10, "R4"); rd_t(3, "R4");
    cyc(0, 0, 0, 0, 0, "R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule